// File: doc/BRIEF.md
# Automatic and Forced Power-Down Controller

This block decides when the host-side buffers of a memory and logic subsystem are shut down to save power. Two routes lead to the same power-down state. In the first, an inactivity counter clocked by a slow free-running clock reaches a threshold after a long stretch with no host bus strobes. In the second, firmware sets a force bit. While powered down, address transitions can no longer wake the memories. Changes on non-address inputs still wake the logic arrays.

A small write/read register port holds four control bits: force, auto-enable, logic low-power enable and turbo select. The same port gives a status word that reports whether the block is down and which route caused it. Bus strobes from the host clock domain reach the slow counter through a toggle and a two-flop synchroniser. The timeout flag returns to the host domain through a second two-flop synchroniser.

Top module: `pdn_ctrl`

## Requirements
- R1: After reset the control word reads 4'b1000 (turbo on; force, auto-enable and low-power off), the status word reads 0, `turbo_o`=1, `logic_lp_o`=0, `pdn_o`=0 and `bus_buf_en_o`=1.
- R2: A write with `reg_addr_i`=0 loads control bits [3:0] as {turbo, low-power enable, auto-enable, force}. A read at address 0 returns them with the upper bits zero.
- R3: With auto-enable set, the block powers down once no strobe has been seen for TIMEOUT+5 slow-clock periods. It does not power down while at most TIMEOUT+1 slow periods have passed since a strobe that lies at least 4 slow periods back.
- R4: The inactivity counter saturates at TIMEOUT and never wraps, so automatic power-down is held for as long as the bus stays idle.
- R5: A bus strobe during automatic power-down clears `pdn_o` within 4 slow-clock periods.
- R6: With force set, `pdn_o` is 1 from the cycle after the write, whatever the auto-enable bit, the counter and the strobes. Clearing force releases it.
- R7: `bus_buf_en_o` is the inverse of `pdn_o`. `mem_wake_o` equals `addr_change_i` while the block is up and is 0 while it is down.
- R8: With low-power enable clear, `logic_wake_o`=1. With it set, `logic_wake_o` = `misc_change_i` OR (`addr_change_i` AND NOT `pdn_o`).
- R9: `turbo_o` follows control bit 3 and `logic_lp_o` follows control bit 2.
- R10: A read at address 1 returns status {by_force (bit 2), by_auto (bit 1), down (bit 0)}. by_auto means auto-enable is set and the counter has timed out.
- R11: Clearing auto-enable ends automatic power-down in the next host cycle. Re-enabling it restarts the count from zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Host clock |
| rst_ni | input | 1 | Active-low asynchronous reset, both domains |
| slow_clk_i | input | 1 | Slow clock for the inactivity counter |
| bus_strobe_i | input | 1 | Host bus activity pulse (host clock domain) |
| addr_change_i | input | 1 | Transition seen on host address inputs |
| misc_change_i | input | 1 | Transition seen on non-address logic inputs |
| reg_we_i | input | 1 | Register write strobe |
| reg_addr_i | input | 1 | 0 = control, 1 = status |
| reg_wdata_i | input | DATA_W | Write data |
| reg_rdata_o | output | DATA_W | Read data for the addressed register |
| pdn_o | output | 1 | Subsystem is powered down |
| bus_buf_en_o | output | 1 | Host address/data buffer enable |
| mem_wake_o | output | 1 | Memory wake permission |
| logic_wake_o | output | 1 | Logic array wake permission |
| turbo_o | output | 1 | Logic arrays in turbo mode |
| logic_lp_o | output | 1 | Logic arrays in low-power mode |

## Verification
The hardest point to reach is the exact boundary of the idle timeout. Around it, the strobe crosses clock domains and the timeout flag crosses back, and each crossing adds a few cycles of uncertainty. The bench uses a short threshold and sweeps the idle gap one slow period at a time, from just after a strobe to well past the threshold. At each step it issues a fresh strobe and samples after a whole number of slow periods. Gaps inside the synchroniser uncertainty band are left unchecked, and those on either side must give the computed result. Saturation is reached by holding the bus idle for several times the threshold. The route back from disabled to re-enabled is reached by waiting for the enable to settle in the slow domain before setting it again.

// File: rtl/pdn_pkg.sv
package pdn_pkg;
  typedef struct packed {
    logic turbo;
    logic lp_en;
    logic auto_en;
    logic force_pd;
  } pdn_ctl_t;

  typedef struct packed {
    logic by_force;
    logic by_auto;
    logic down;
  } pdn_stat_t;

  localparam pdn_ctl_t CtlReset = '{turbo: 1'b1, lp_en: 1'b0, auto_en: 1'b0, force_pd: 1'b0};
  localparam int CtlW  = $bits(pdn_ctl_t);
  localparam int StatW = $bits(pdn_stat_t);
endpackage

// File: rtl/pdn_sync.sv
module pdn_sync #(
  parameter int W      = 1,
  parameter int STAGES = 2
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);
  logic [W-1:0] stage_q [STAGES];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int i = 0; i < STAGES; i++) stage_q[i] <= '0;
    end else begin
      stage_q[0] <= d_i;
      for (int i = 1; i < STAGES; i++) stage_q[i] <= stage_q[i-1];
    end
  end

  assign q_o = stage_q[STAGES-1];
endmodule

// File: rtl/pdn_regs.sv
module pdn_regs
  import pdn_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              we_i,
  input  logic              addr_i,
  input  logic [DATA_W-1:0] wdata_i,
  input  pdn_stat_t         stat_i,
  output pdn_ctl_t          ctl_o,
  output logic [DATA_W-1:0] rdata_o
);
  pdn_ctl_t ctl_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) ctl_q <= CtlReset;
    else if (we_i && !addr_i) ctl_q <= pdn_ctl_t'(wdata_i[CtlW-1:0]);
  end

  always_comb begin
    rdata_o = '0;
    if (!addr_i) rdata_o[CtlW-1:0]  = ctl_q;
    else         rdata_o[StatW-1:0] = stat_i;
  end

  assign ctl_o = ctl_q;
endmodule

// File: rtl/pdn_idle_cnt.sv
module pdn_idle_cnt #(
  parameter int TIMEOUT = 1000,
  localparam int CntW   = $clog2(TIMEOUT + 1)
) (
  input  logic            slow_clk_i,
  input  logic            rst_ni,
  input  logic            act_tgl_i,  // host-domain toggle, one flip per strobe
  input  logic            en_i,       // host-domain level
  output logic [CntW-1:0] cnt_o,
  output logic            expired_o
);
  localparam logic [CntW-1:0] Limit = CntW'(TIMEOUT);

  logic [1:0] sync_s;
  logic       tgl_d_q, act_s;
  logic [CntW-1:0] cnt_q, cnt_d;
  logic       expired_q;

  pdn_sync #(.W(2), .STAGES(2)) u_sync (
    .clk_i  (slow_clk_i),
    .rst_ni (rst_ni),
    .d_i    ({en_i, act_tgl_i}),
    .q_o    (sync_s)
  );

  assign act_s = sync_s[0] ^ tgl_d_q;

  always_comb begin
    if (!sync_s[1] || act_s) cnt_d = '0;
    else if (cnt_q != Limit) cnt_d = cnt_q + 1'b1;
    else                     cnt_d = cnt_q;  // saturate
  end

  always_ff @(posedge slow_clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      tgl_d_q   <= 1'b0;
      cnt_q     <= '0;
      expired_q <= 1'b0;
    end else begin
      tgl_d_q   <= sync_s[0];
      cnt_q     <= cnt_d;
      expired_q <= (cnt_d == Limit);  // registered so the crossing sees one clean bit
    end
  end

  assign cnt_o     = cnt_q;
  assign expired_o = expired_q;
endmodule

// File: rtl/pdn_ctrl.sv
module pdn_ctrl
  import pdn_pkg::*;
#(
  parameter int TIMEOUT = 1000,
  parameter int DATA_W  = 8,
  localparam int CntW   = $clog2(TIMEOUT + 1)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              slow_clk_i,
  input  logic              bus_strobe_i,
  input  logic              addr_change_i,
  input  logic              misc_change_i,
  input  logic              reg_we_i,
  input  logic              reg_addr_i,
  input  logic [DATA_W-1:0] reg_wdata_i,
  output logic [DATA_W-1:0] reg_rdata_o,
  output logic              pdn_o,
  output logic              bus_buf_en_o,
  output logic              mem_wake_o,
  output logic              logic_wake_o,
  output logic              turbo_o,
  output logic              logic_lp_o
);
  pdn_ctl_t        ctl;
  pdn_stat_t       stat;
  logic            act_tgl_q;
  logic            expired_s, expired_h;
  logic [CntW-1:0] idle_cnt;
  logic            auto_pd, force_pd, pd;

  pdn_regs #(.DATA_W(DATA_W)) u_regs (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .we_i    (reg_we_i),
    .addr_i  (reg_addr_i),
    .wdata_i (reg_wdata_i),
    .stat_i  (stat),
    .ctl_o   (ctl),
    .rdata_o (reg_rdata_o)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)           act_tgl_q <= 1'b0;
    else if (bus_strobe_i) act_tgl_q <= ~act_tgl_q;
  end

  pdn_idle_cnt #(.TIMEOUT(TIMEOUT)) u_idle (
    .slow_clk_i (slow_clk_i),
    .rst_ni     (rst_ni),
    .act_tgl_i  (act_tgl_q),
    .en_i       (ctl.auto_en),
    .cnt_o      (idle_cnt),
    .expired_o  (expired_s)
  );

  pdn_sync #(.W(1), .STAGES(2)) u_exp_sync (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .d_i    (expired_s),
    .q_o    (expired_h)
  );

  assign force_pd = ctl.force_pd;
  assign auto_pd  = ctl.auto_en & expired_h;
  assign pd       = force_pd | auto_pd;

  assign stat = '{by_force: force_pd, by_auto: auto_pd, down: pd};

  assign pdn_o        = pd;
  assign bus_buf_en_o = ~pd;
  assign mem_wake_o   = addr_change_i & ~pd;
  assign logic_wake_o = ~ctl.lp_en | misc_change_i | (addr_change_i & ~pd);
  assign turbo_o      = ctl.turbo;
  assign logic_lp_o   = ctl.lp_en;
endmodule

// File: rtl/pdn_ctrl_chk.sv
module pdn_ctrl_chk #(
  parameter int TIMEOUT = 1000,
  parameter int DATA_W  = 8,
  localparam int CntW   = $clog2(TIMEOUT + 1)
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              slow_clk_i,
  input logic              reg_we_i,
  input logic              reg_addr_i,
  input logic [DATA_W-1:0] reg_wdata_i,
  input logic              pdn_o,
  input logic              bus_buf_en_o,
  input logic              mem_wake_o,
  input logic              logic_wake_o,
  input logic              logic_lp_o,
  input logic              turbo_o,
  input logic              force_i,
  input logic [CntW-1:0]   cnt_i
);
  assert_cnt_sat_R4: assert property (@(posedge slow_clk_i) disable iff (!rst_ni)
    cnt_i <= CntW'(TIMEOUT));

  assert_force_down_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    force_i |-> pdn_o);

  assert_mem_blocked_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pdn_o |-> (!mem_wake_o && !bus_buf_en_o));

  assert_lp_off_awake_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !logic_lp_o |-> logic_wake_o);

  assert_ctl_write_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (reg_we_i && !reg_addr_i) |=> (turbo_o == $past(reg_wdata_i[3])) &&
                                  (logic_lp_o == $past(reg_wdata_i[2])) &&
                                  (force_i == $past(reg_wdata_i[0])));
endmodule

bind pdn_ctrl pdn_ctrl_chk #(.TIMEOUT(TIMEOUT), .DATA_W(DATA_W)) u_chk (
  .clk_i        (clk_i),
  .rst_ni       (rst_ni),
  .slow_clk_i   (slow_clk_i),
  .reg_we_i     (reg_we_i),
  .reg_addr_i   (reg_addr_i),
  .reg_wdata_i  (reg_wdata_i),
  .pdn_o        (pdn_o),
  .bus_buf_en_o (bus_buf_en_o),
  .mem_wake_o   (mem_wake_o),
  .logic_wake_o (logic_wake_o),
  .logic_lp_o   (logic_lp_o),
  .turbo_o      (turbo_o),
  .force_i      (force_pd),
  .cnt_i        (idle_cnt)
);

// File: tb/pdn_ctrl_tb_top.sv
module pdn_ctrl_tb_top;
  localparam int T      = 6;
  localparam int DW     = 8;
  localparam int SLOW_N = 10;  // host cycles per slow cycle

  logic clk = 1'b0, slow_clk = 1'b0, rst_n = 1'b0;
  logic strobe = 1'b0, addr_chg = 1'b0, misc_chg = 1'b0;
  logic we = 1'b0, addr = 1'b0;
  logic [DW-1:0] wdata = '0, rdata;
  logic pdn, buf_en, mem_wake, logic_wake, turbo, lp;

  int n_chk = 0, n_fail = 0;
  bit done = 1'b0;

  always #2  clk = ~clk;
  always #20 slow_clk = ~slow_clk;

  pdn_ctrl #(.TIMEOUT(T), .DATA_W(DW)) dut_i (
    .clk_i(clk), .rst_ni(rst_n), .slow_clk_i(slow_clk),
    .bus_strobe_i(strobe), .addr_change_i(addr_chg), .misc_change_i(misc_chg),
    .reg_we_i(we), .reg_addr_i(addr), .reg_wdata_i(wdata), .reg_rdata_o(rdata),
    .pdn_o(pdn), .bus_buf_en_o(buf_en), .mem_wake_o(mem_wake),
    .logic_wake_o(logic_wake), .turbo_o(turbo), .logic_lp_o(lp)
  );

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic wr(logic [3:0] v);
    @(negedge clk); we = 1'b1; addr = 1'b0; wdata = DW'(v);
    @(negedge clk); we = 1'b0;
  endtask

  task automatic rd(logic a, output logic [DW-1:0] v);
    @(negedge clk); addr = a; #1 v = rdata;
  endtask

  task automatic pulse();
    @(negedge clk); strobe = 1'b1;
    @(negedge clk); strobe = 1'b0;
  endtask

  task automatic slow_wait(int n);
    repeat (n * SLOW_N) @(negedge clk);
  endtask

  initial begin
    #400000;
    n_chk++; n_fail++;
    $display("FAIL watchdog: actual hung expected done");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    logic [DW-1:0] v;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R1 reset state
    rd(1'b0, v); chk("R1 ctl", v, 8'h08);
    rd(1'b1, v); chk("R1 stat", v, 8'h00);
    chk("R1 outs", {turbo, lp, pdn, buf_en}, 4'b1001);

    // R2, R9 write/read sweep of all control values without force/auto
    for (int k = 0; k < 4; k++) begin
      wr({k[1], k[0], 2'b00});
      rd(1'b0, v); chk("R2 readback", v, {4'h0, k[1], k[0], 2'b00});
      chk("R9 mode outs", {turbo, lp}, {k[1], k[0]});
    end
    @(negedge clk); we = 1'b1; addr = 1'b0; wdata = 8'hF8;
    @(negedge clk); we = 1'b0;
    rd(1'b0, v); chk("R2 upper bits zero", v, 8'h08);

    // R6/R7/R8 exhaustive wake sweep over force, lp, addr, misc
    for (int k = 0; k < 16; k++) begin
      logic f, l, a, m;
      {f, l, a, m} = k[3:0];
      wr({1'b1, l, 1'b0, f});
      addr_chg = a; misc_chg = m;
      #1;
      chk("R6 force pd", pdn, f);
      chk("R7 buf en", buf_en, !f);
      chk("R7 mem wake", mem_wake, a & !f);
      chk("R8 logic wake", logic_wake, !l | m | (a & !f));
    end
    addr_chg = 1'b0; misc_chg = 1'b0;
    wr(4'b1000);
    chk("R6 force released", pdn, 1'b0);

    // R3 idle gap sweep
    wr(4'b1010);
    slow_wait(3);
    for (int g = 4; g <= T + 7; g++) begin
      pulse();
      slow_wait(g);
      if (g <= T + 1) chk("R3 no early pd", pdn, 1'b0);
      else if (g >= T + 5) chk("R3 timeout pd", pdn, 1'b1);
    end

    // R4 saturation: hold idle long
    slow_wait(4 * T + 3);
    chk("R4 still down", pdn, 1'b1);
    rd(1'b1, v); chk("R10 auto status", v, 8'h03);
    chk("R7 buf off", buf_en, 1'b0);

    // R10 both causes
    wr(4'b1011);
    rd(1'b1, v); chk("R10 both status", v, 8'h07);
    wr(4'b1010);

    // R5 exit on strobe
    pulse();
    slow_wait(4);
    chk("R5 wake on strobe", pdn, 1'b0);
    slow_wait(T + 5);
    chk("R5 down again", pdn, 1'b1);

    // R6 force holds through strobes
    wr(4'b1001);
    for (int i = 0; i < 3; i++) begin pulse(); slow_wait(2); end
    chk("R6 force holds", pdn, 1'b1);
    rd(1'b1, v); chk("R10 force status", v, 8'h05);
    wr(4'b1000);

    // R11 disable ends auto pd, re-enable restarts count
    wr(4'b1010);
    slow_wait(T + 5);
    chk("R11 pre down", pdn, 1'b1);
    wr(4'b1000);
    chk("R11 disable exits", pdn, 1'b0);
    slow_wait(5);
    wr(4'b1010);
    chk("R11 reenable up", pdn, 1'b0);
    slow_wait(T);
    chk("R11 count restarted", pdn, 1'b0);
    slow_wait(6);
    chk("R11 timeout again", pdn, 1'b1);

    done = 1'b1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule